// File: doc/BRIEF.md
# Approximate Wallace Tree Multiplier

This block multiplies two unsigned 8-bit operands into a 16-bit product. It gives up some accuracy in exchange for a shorter carry path and fewer cells. An AND array forms the partial-product rows. In the approximate settings, neighbouring rows are merged by a bitwise OR, so half as many rows reach the reduction tree. An exact carry-save tree then cuts the rows down to two. A ripple adder built from deliberately inexact cells adds those two rows.

A compile-time parameter selects one of five builds. Setting 0 is the exact reference: no row merging and exact adder cells. Settings 1 to 4 each use row merging together with a different inexact three-input adder cell. Operands are captured in an input register and the product is held in an output register. Both registers clear under an asynchronous active-low reset.

Top module: `approx_wallace_mult`

## Requirements
- R1: Partial-product row i is op_a ANDed with op_b[i], weighted by 2^i. With VARIANT = 0, product equals op_a × op_b exactly for every operand pair.
- R2: With VARIANT 1 to 4, row 2k and row 2k+1 are merged into one row by a bitwise OR of their weight-aligned bits (k = 0..3), which leaves four rows.
- R3: The tree repeatedly takes rows in order, in groups of three, starting from the first row. Each group becomes an exact sum row followed by its majority row shifted left by one bit. Rows left over after the groups are appended after all group outputs, in their original order. This repeats until two rows, X (first) and Y (second), remain.
- R4: The final adder is a ripple from bit 0 upward. Bit 0 is a half adder with carry = X0 AND Y0. Its sum is X0 XOR Y0 for VARIANT 0 and X0 OR Y0 otherwise. Each higher bit i is a three-input cell with A = X[i], B = Y[i] and Ci = the carry from bit i-1. The carry out of bit 15 is dropped.
- R5: VARIANT 1 cell: sum = A XOR B XOR Ci, carry = (A AND B) OR Ci.
- R6: VARIANT 2 cell: sum = A XOR B XOR Ci, carry = (A XOR B) AND Ci.
- R7: VARIANT 3 cell: sum = (A OR B) XOR Ci, carry = (A OR B) AND Ci.
- R8: VARIANT 4 cell: sum = A XOR B XOR Ci, carry = A, independent of B and Ci.
- R9: When either operand is zero, the product is zero in every variant.
- R10: During reset the product reads 0. After reset, the product for operands applied before a rising edge appears after the following rising edge, two edges in total.
- R11: Once reset has been released, no product bit is X or Z in any variant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | W (8) | Unsigned multiplicand |
| op_b | input | W (8) | Unsigned multiplier |
| product | output | 2W (16) | Registered, possibly approximate, product |

## Verification
Each product is due two rising edges after its operands are applied: one edge loads the input register and the next loads the output register. The bench applies a new operand pair on every falling edge. On that same falling edge, before applying the next pair, it compares the product against the pair it applied two falling edges earlier. Once the sweep has drained, one further pair is applied to confirm that the product holds its old value after one edge and changes only after the second. Every variant is built side by side and swept over all 65,536 operand pairs. The exact build is compared against arithmetic multiplication, and each approximate build is compared against a bench model of the row merge, tree order and cell equations.

// File: rtl/approx_mult_pkg.sv
package approx_mult_pkg;

  // Build selector encoding
  localparam int VARIANT_EXACT = 0;
  localparam int VARIANT_MAX   = 4;

  // Number of rows entering the carry-save tree
  function automatic int tree_rows(input int width, input int variant);
    return (variant == VARIANT_EXACT) ? width : width / 2;
  endfunction

endpackage

// File: rtl/approx_pp_gen.sv
module approx_pp_gen #(
  parameter int W       = 8,
  parameter int VARIANT = 1,
  parameter int NROWS   = 4,
  parameter int PW      = 2 * W
) (
  input  logic [W-1:0]             op_a,
  input  logic [W-1:0]             op_b,
  output logic [NROWS-1:0][PW-1:0] rows
);
  import approx_mult_pkg::*;

  logic [W-1:0][PW-1:0] raw;

  // AND array, each row weighted by its multiplier bit (R1)
  for (genvar i = 0; i < W; i++) begin : g_raw
    assign raw[i] = PW'(op_a & {W{op_b[i]}}) << i;
  end

  if (VARIANT == VARIANT_EXACT) begin : g_exact
    assign rows = raw;
  end else begin : g_merge
    // Lossy pairwise OR merge of neighbouring rows (R2)
    for (genvar k = 0; k < NROWS; k++) begin : g_pair
      assign rows[k] = raw[2*k] | raw[2*k+1];
    end
  end

  // The merged rows never sum above the true product; exact build keeps it
  logic [PW+3:0] row_total;
  always_comb begin
    row_total = '0;
    for (int r = 0; r < NROWS; r++) row_total = row_total + (PW+4)'(rows[r]);
    if (!$isunknown({op_a, op_b})) begin
      p_or_bound_r2: assert (row_total <= (PW+4)'(op_a) * (PW+4)'(op_b) &&
                             (VARIANT != VARIANT_EXACT ||
                              row_total == (PW+4)'(op_a) * (PW+4)'(op_b)));
    end
  end

endmodule

// File: rtl/approx_csa_tree.sv
module approx_csa_tree #(
  parameter int NROWS = 4,
  parameter int PW    = 16
) (
  input  logic [NROWS-1:0][PW-1:0] rows,
  output logic [PW-1:0]            row_x,
  output logic [PW-1:0]            row_y
);
  localparam int LEVELS = NROWS;

  logic [PW-1:0] cur [NROWS];
  logic [PW-1:0] nxt [NROWS];

  // Exact carry-save reduction, groups of three in order, leftovers last (R3)
  always_comb begin
    int n;
    int m;
    for (int r = 0; r < NROWS; r++) cur[r] = rows[r];
    for (int r = 0; r < NROWS; r++) nxt[r] = '0;
    n = NROWS;
    for (int lv = 0; lv < LEVELS; lv++) begin
      if (n > 2) begin
        for (int r = 0; r < NROWS; r++) nxt[r] = '0;
        m = 0;
        for (int g = 0; g < NROWS / 3; g++) begin
          if (3 * g + 2 < n) begin
            nxt[m]   = cur[3*g] ^ cur[3*g+1] ^ cur[3*g+2];
            nxt[m+1] = ((cur[3*g] & cur[3*g+1]) | (cur[3*g] & cur[3*g+2]) |
                        (cur[3*g+1] & cur[3*g+2])) << 1;
            m = m + 2;
          end
        end
        for (int r = 0; r < NROWS; r++) begin
          if (r >= 3 * (n / 3) && r < n) begin
            nxt[m] = cur[r];
            m = m + 1;
          end
        end
        for (int r = 0; r < NROWS; r++) cur[r] = nxt[r];
        n = m;
      end
    end
    row_x = cur[0];
    row_y = cur[1];
  end

  // The two surviving rows carry the same total as the rows fed in
  logic [PW+3:0] in_total;
  always_comb begin
    in_total = '0;
    for (int r = 0; r < NROWS; r++) in_total = in_total + (PW+4)'(rows[r]);
    if (!$isunknown(rows)) begin
      p_tree_sum_r3: assert ((PW+4)'(row_x) + (PW+4)'(row_y) == in_total);
    end
  end

endmodule

// File: rtl/approx_final_adder.sv
module approx_final_adder #(
  parameter int PW      = 16,
  parameter int VARIANT = 1
) (
  input  logic [PW-1:0] row_x,
  input  logic [PW-1:0] row_y,
  output logic [PW-1:0] sum
);
  import approx_mult_pkg::*;

  logic [PW-2:0] cy;  // cy[i] is the carry out of bit i

  // Bit 0: exact or OR-sum half adder (R4)
  if (VARIANT == VARIANT_EXACT) begin : g_ha_exact
    assign sum[0] = row_x[0] ^ row_y[0];
  end else begin : g_ha_inexact
    assign sum[0] = row_x[0] | row_y[0];
  end
  assign cy[0] = row_x[0] & row_y[0];

  for (genvar i = 1; i < PW; i++) begin : g_bit
    logic a, b, ci;
    assign a  = row_x[i];
    assign b  = row_y[i];
    assign ci = cy[i-1];

    if (VARIANT == 3) begin : g_sum_or
      assign sum[i] = (a | b) ^ ci;                     // R7
    end else begin : g_sum_xor
      assign sum[i] = a ^ b ^ ci;
    end

    if (i < PW - 1) begin : g_carry
      case (VARIANT)
        1:       begin : g_c1 assign cy[i] = (a & b) | ci;  end   // R5
        2:       begin : g_c2 assign cy[i] = (a ^ b) & ci;  end   // R6
        3:       begin : g_c3 assign cy[i] = (a | b) & ci;  end   // R7
        4:       begin : g_c4 assign cy[i] = a;             end   // R8
        default: begin : g_c0 assign cy[i] = (a & b) | ((a ^ b) & ci); end
      endcase
    end
  end

  if (VARIANT == VARIANT_EXACT) begin : g_chk_exact
    always_comb begin
      if (!$isunknown({row_x, row_y})) begin
        p_adder_exact_r1: assert (sum == PW'(row_x + row_y));
      end
    end
  end

endmodule

// File: rtl/approx_wallace_mult.sv
module approx_wallace_mult #(
  parameter int W       = 8,
  parameter int VARIANT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  output logic [2*W-1:0]   product
);
  import approx_mult_pkg::*;

  localparam int PW    = 2 * W;
  localparam int NROWS = tree_rows(W, VARIANT);

  logic [W-1:0]              a_q, b_q;
  logic [W-1:0]              a_d, b_d;
  logic [NROWS-1:0][PW-1:0]  rows;
  logic [PW-1:0]             row_x, row_y;
  logic [PW-1:0]             product_d;

  // Next-state
  always_comb begin
    a_d = op_a;
    b_d = op_b;
  end

  // Input register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  approx_pp_gen #(.W(W), .VARIANT(VARIANT), .NROWS(NROWS), .PW(PW)) u_pp (
    .op_a (a_q),
    .op_b (b_q),
    .rows (rows)
  );

  approx_csa_tree #(.NROWS(NROWS), .PW(PW)) u_tree (
    .rows  (rows),
    .row_x (row_x),
    .row_y (row_y)
  );

  approx_final_adder #(.PW(PW), .VARIANT(VARIANT)) u_add (
    .row_x (row_x),
    .row_y (row_y),
    .sum   (product_d)
  );

  // Output register (R10)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) product <= '0;
    else        product <= product_d;
  end

  p_zero_operand_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (a_q == '0 || b_q == '0) |=> product == '0);

  p_known_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(product));

  if (VARIANT == VARIANT_EXACT) begin : g_exact_chk
    p_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> product == PW'($past(a_q)) * PW'($past(b_q)));
  end

endmodule

// File: tb/approx_wallace_mult_test.sv
module approx_wallace_mult_test;

  localparam int W  = 8;
  localparam int PW = 16;
  localparam int NV = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] op_a, op_b;
  logic [PW-1:0] prod [NV];

  int chk_cnt  = 0;
  int fail_cnt = 0;
  int err_cnt  [NV];
  longint err_sum [NV];

  always #2 clk = ~clk;

  for (genvar v = 0; v < NV; v++) begin : g_var
    approx_wallace_mult #(.W(W), .VARIANT(v)) uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .op_a    (op_a),
      .op_b    (op_b),
      .product (prod[v])
    );
  end

  function automatic string tag_of(int v);
    case (v)
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      default: return "R1";
    endcase
  endfunction

  // Bench model: AND rows (R1), OR merge (R2), ordered CSA tree (R3), ripple (R4)
  function automatic int model(int v, int a, int b);
    int r [8];
    int t [8];
    int n, m, g, c, x, y, sb, cb, res;
    for (int i = 0; i < 8; i++) r[i] = ((b >> i) & 1) ? (a << i) : 0;
    n = 8;
    if (v != 0) begin
      for (int k = 0; k < 4; k++) r[k] = r[2*k] | r[2*k+1];
      n = 4;
    end
    while (n > 2) begin
      m = 0;
      g = 0;
      while (g + 3 <= n) begin
        t[m]   = r[g] ^ r[g+1] ^ r[g+2];
        t[m+1] = (((r[g] & r[g+1]) | (r[g] & r[g+2]) | (r[g+1] & r[g+2])) << 1) & 16'hFFFF;
        m = m + 2;
        g = g + 3;
      end
      while (g < n) begin
        t[m] = r[g];
        m = m + 1;
        g = g + 1;
      end
      for (int i = 0; i < m; i++) r[i] = t[i];
      n = m;
    end
    x = r[0] & 1;
    y = r[1] & 1;
    res = (v == 0) ? (x ^ y) : (x | y);
    c = x & y;
    for (int i = 1; i < 16; i++) begin
      x = (r[0] >> i) & 1;
      y = (r[1] >> i) & 1;
      sb = (v == 3) ? ((x | y) ^ c) : (x ^ y ^ c);
      case (v)
        1: cb = (x & y) | c;
        2: cb = (x ^ y) & c;
        3: cb = (x | y) & c;
        4: cb = x;
        default: cb = (x & y) | ((x ^ y) & c);
      endcase
      res = res | (sb << i);
      c = cb;
    end
    return res;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    chk_cnt++;
    if (!ok) begin
      fail_cnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_pair(input int idx);
    int a, b, exp, act;
    a = idx & 255;
    b = idx >> 8;
    for (int v = 0; v < NV; v++) begin
      check(!$isunknown(prod[v]), "R11", 0, 0, $sformatf("v%0d unknown bits a=%0d b=%0d", v, a, b));
      act = int'(prod[v]);
      exp = (v == 0) ? a * b : model(v, a, b);
      check(act == exp, tag_of(v), act, exp, $sformatf("v%0d a=%0d b=%0d", v, a, b));
      if (a == 0 || b == 0)
        check(act == 0, "R9", act, 0, $sformatf("v%0d zero operand a=%0d b=%0d", v, a, b));
      if (act != a * b) begin
        err_cnt[v]++;
        err_sum[v] += longint'((act > a * b) ? act - a * b : a * b - act);
      end
    end
  endtask

  initial begin
    for (int v = 0; v < NV; v++) begin
      err_cnt[v] = 0;
      err_sum[v] = 0;
    end
    rst_n = 1'b0;
    op_a  = 8'd200;
    op_b  = 8'd123;
    repeat (3) @(negedge clk);
    for (int v = 0; v < NV; v++)
      check(prod[v] == '0, "R10", int'(prod[v]), 0, $sformatf("v%0d reset value", v));
    rst_n = 1'b1;
    // Operands applied at falling edge k are checked at falling edge k+2 (R10)
    for (int idx = 0; idx < 65536 + 2; idx++) begin
      if (idx >= 2) check_pair(idx - 2);
      if (idx < 65536) begin
        op_a = 8'(idx & 255);
        op_b = 8'(idx >> 8);
      end
      @(negedge clk);
    end
    // Latency edge case: last pair 255x255 still visible one edge after a new pair
    op_a = 8'd3;
    op_b = 8'd5;
    @(negedge clk);
    check(prod[0] == 16'd65025, "R10", int'(prod[0]), 65025, "product after one edge");
    @(negedge clk);
    check(prod[0] == 16'd15, "R10", int'(prod[0]), 15, "product after two edges");
    for (int v = 1; v < NV; v++)
      $display("variant %0d: error rate %0.4f, mean error distance %0.3f", v,
               real'(err_cnt[v]) / 65536.0, real'(err_sum[v]) / 65536.0);
    $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
    $finish;
  end

  initial begin
    #(4 * 200000);
    chk_cnt++;
    fail_cnt++;
    $display("FAIL R10 watchdog expired: actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
    $finish;
  end

endmodule